// File: doc/BRIEF.md
# Compact 16-bit Teaching Processor Core

This block is a single-issue core with no pipeline. Each clock cycle it reads one 16-bit instruction word from an external instruction memory and executes it. The memory is addressed by a 12-bit word index. The memory must return the word for `imem_addr` in the same cycle. The core holds sixteen 16-bit general-purpose registers, a three-bit compare flag set and an internal return-address stack. The opcode sits in the top nibble of the word. The low twelve bits are split into three nibbles: A is bits [11:8], B is bits [7:4] and C is bits [3:0].

The core exchanges data with the outside world through two 16-bit ports. Each port uses a valid/ready handshake. The core stays on an input or output instruction until the handshake completes. Three events stop the core for good: an illegal opcode, an illegal branch condition, or a misuse of the return stack. When one occurs, the core freezes at the offending instruction and reports a fault code. Only reset releases it.

Top module: `tiny16_core`

## Requirements
- R1: While reset is asserted, and right after it is released, the fetch address is 0, `halted` is 0 and `fault_code` is 0. All registers read as 0.
- R2: Opcode 0 copies register C into register B. Opcode 1 writes the 8-bit field [7:0], zero-extended, into register A.
- R3: Opcodes 2 (add), 3 (subtract, B minus C) and 12 (multiply) write the low 16 bits of (register B op register C) into register A.
- R4: Opcode 4 computes register B minus register C. It updates only the flags and writes no register. No other opcode changes the flags.
- R5: Opcode 5 tests the flags from the last compare, as signed two's complement values, using the condition in A: 0 equal, 1 less, 2 greater, 3 less-or-equal, 4 greater-or-equal, 5 not-equal.
- R6: The branch offset is sign-magnitude. Bit 7 set means backward, and bits [6:0] give the distance in words. A taken branch goes to its own address plus or minus that distance. A branch whose condition is false goes to the next word.
- R7: Opcode 6 jumps to the 12-bit address in bits [11:0]. Sequential fetch wraps from 0xFFF to 0x000.
- R8: Opcode 7 saves the address after itself and jumps to bits [11:0]. Opcode 8 resumes at the most recently saved address, in last-in first-out order, up to 8 nested levels.
- R9: A call with 8 addresses saved, or a return with none saved, halts the core at that instruction with `fault_code` 3.
- R10: Opcodes 13 to 15 halt the core with `fault_code` 1. A branch whose condition field is 6 to 15 halts it with `fault_code` 2. In both cases the fetch address stays at the faulting word.
- R11: Opcode 10 raises `in_ready`. The core holds its address until `in_valid` is seen, then writes `in_data` into register C.
- R12: Opcode 11 raises `out_valid` with register C on `out_data`. The core holds its address until `out_ready` is seen.
- R13: Once halted, the core keeps its fault code and fetch address and shows no port activity until reset.
- R14: Opcode 9 changes nothing except advancing the fetch address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 12 | Word address of the instruction being executed |
| imem_data | input | 16 | Instruction word at `imem_addr`, same cycle |
| in_valid | input | 1 | Input port has a word |
| in_ready | output | 1 | Core is executing an input instruction |
| in_data | input | 16 | Input port word |
| out_valid | output | 1 | Core is executing an output instruction |
| out_ready | input | 1 | Output port accepts the word |
| out_data | output | 16 | Output port word |
| halted | output | 1 | Core has stopped on a fault |
| fault_code | output | 2 | 0 none, 1 bad opcode, 2 bad condition, 3 return stack |

## Verification
The properties assume that the instruction memory answers combinationally. `imem_data` must always be the word stored at the current `imem_addr` and never X after reset, so the opcode each property decodes is the one being executed. The bench models the memory as a 256-word array indexed by the low address bits. Every unused word is filled with an illegal opcode, so each program ends in a defined halt. The port partners in the bench change `in_valid`, `in_data` and `out_ready` only at falling edges, and `in_data` stays stable while `in_valid` is high and unaccepted.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

    localparam int INSN_W   = 16;
    localparam int PC_W     = 12;
    localparam int REG_W    = 4;
    localparam int NUM_REGS = 1 << REG_W;

    localparam logic [3:0] OPC_MOV  = 4'd0;
    localparam logic [3:0] OPC_MOVI = 4'd1;
    localparam logic [3:0] OPC_ADD  = 4'd2;
    localparam logic [3:0] OPC_SUB  = 4'd3;
    localparam logic [3:0] OPC_CMP  = 4'd4;
    localparam logic [3:0] OPC_BCC  = 4'd5;
    localparam logic [3:0] OPC_JMP  = 4'd6;
    localparam logic [3:0] OPC_CALL = 4'd7;
    localparam logic [3:0] OPC_RET  = 4'd8;
    localparam logic [3:0] OPC_NOP  = 4'd9;
    localparam logic [3:0] OPC_IN   = 4'd10;
    localparam logic [3:0] OPC_OUT  = 4'd11;
    localparam logic [3:0] OPC_MUL  = 4'd12;

    localparam logic [3:0] LAST_COND = 4'd5;

    typedef enum logic [3:0] {
        CL_WB, CL_CMP, CL_BCC, CL_JMP, CL_CALL,
        CL_RET, CL_NOP, CL_IN, CL_OUT, CL_BAD
    } cls_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL, ALU_PASS} alu_op_e;

    typedef enum logic [1:0] {WB_ALU, WB_IMM, WB_PORT} wb_sel_e;

    typedef enum logic [1:0] {FLT_NONE, FLT_OPCODE, FLT_COND, FLT_STACK} fault_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
    } flags_t;

    typedef struct packed {
        cls_e             cls;
        alu_op_e          alu_op;
        wb_sel_e          wb_sel;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rx;
        logic [REG_W-1:0] ry;
        logic [3:0]       cond;
        logic             cond_ok;
        logic [7:0]       imm;
        logic [PC_W-1:0]  abs_tgt;
        logic             off_neg;
        logic [6:0]       off_mag;
    } dec_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        flags_t          flags;
        logic            halted;
        fault_e          fault;
    } core_st_t;

    function automatic logic cond_hit(input logic [3:0] cond, input flags_t f);
        logic lt;
        lt = f.n ^ f.v;
        case (cond)
            4'd0:    cond_hit = f.z;
            4'd1:    cond_hit = lt;
            4'd2:    cond_hit = !f.z && !lt;
            4'd3:    cond_hit = f.z || lt;
            4'd4:    cond_hit = !lt;
            4'd5:    cond_hit = !f.z;
            default: cond_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tiny16_decode.sv
module tiny16_decode
    import tiny16_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic [3:0] op;
    logic [3:0] fa;
    logic [3:0] fb;
    logic [3:0] fc;

    assign op = insn[15:12];
    assign fa = insn[11:8];
    assign fb = insn[7:4];
    assign fc = insn[3:0];

    always_comb begin
        dec         = '0;
        dec.cls     = CL_BAD;
        dec.alu_op  = ALU_PASS;
        dec.wb_sel  = WB_ALU;
        dec.rd      = fa;
        dec.rx      = fb;
        dec.ry      = fc;
        dec.cond    = fa;
        dec.cond_ok = (fa <= LAST_COND);
        dec.imm     = insn[7:0];
        dec.abs_tgt = insn[PC_W-1:0];
        dec.off_neg = insn[7];
        dec.off_mag = insn[6:0];
        case (op)
            OPC_MOV: begin
                dec.cls = CL_WB;
                dec.rd  = fb;
            end
            OPC_MOVI: begin
                dec.cls    = CL_WB;
                dec.wb_sel = WB_IMM;
            end
            OPC_ADD: begin
                dec.cls    = CL_WB;
                dec.alu_op = ALU_ADD;
            end
            OPC_SUB: begin
                dec.cls    = CL_WB;
                dec.alu_op = ALU_SUB;
            end
            OPC_MUL: begin
                dec.cls    = CL_WB;
                dec.alu_op = ALU_MUL;
            end
            OPC_CMP: begin
                dec.cls    = CL_CMP;
                dec.alu_op = ALU_SUB;
            end
            OPC_BCC:  dec.cls = CL_BCC;
            OPC_JMP:  dec.cls = CL_JMP;
            OPC_CALL: dec.cls = CL_CALL;
            OPC_RET:  dec.cls = CL_RET;
            OPC_NOP:  dec.cls = CL_NOP;
            OPC_IN: begin
                dec.cls    = CL_IN;
                dec.wb_sel = WB_PORT;
                dec.rd     = fc;
            end
            OPC_OUT:  dec.cls = CL_OUT;
            default:  dec.cls = CL_BAD;
        endcase
    end

endmodule

// File: rtl/tiny16_alu.sv
module tiny16_alu
    import tiny16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] res,
    output flags_t            flags
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;

    always_comb begin
        diff    = x - y;
        flags.z = (diff == '0);
        flags.n = diff[MSB];
        flags.v = (x[MSB] != y[MSB]) && (diff[MSB] != x[MSB]);
        case (op)
            ALU_ADD: res = x + y;
            ALU_SUB: res = diff;
            ALU_MUL: res = x * y;
            default: res = y;
        endcase
    end

endmodule

// File: rtl/tiny16_retstack.sv
module tiny16_retstack #(
    parameter int DEPTH = 8,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val,
    output logic         full,
    output logic         empty
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [W-1:0]     mem_d [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    assign wr_idx  = IDX_W'(cnt_q);
    assign top_idx = IDX_W'(cnt_q - 1'b1);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign top_val = mem_q[top_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign mem_d[g] = (push && wr_idx == IDX_W'(g)) ? push_val : mem_q[g];
    end

    always_comb begin
        cnt_d = cnt_q;
        if (push && !full) begin
            cnt_d = cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
    import tiny16_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              halted,
    output logic [1:0]        fault_code
);

    localparam int IMM_PAD = DATA_W - 8;

    core_st_t st_q;
    core_st_t st_d;
    dec_t     dec;

    logic [DATA_W-1:0] rf_q [NUM_REGS];
    logic [DATA_W-1:0] rf_d [NUM_REGS];
    logic              rf_we;
    logic [REG_W-1:0]  rf_wa;
    logic [DATA_W-1:0] rf_wd;

    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flags;

    logic              stk_push;
    logic              stk_pop;
    logic [PC_W-1:0]   stk_top;
    logic              stk_full;
    logic              stk_empty;

    logic [PC_W-1:0]   pc_inc;
    logic [PC_W-1:0]   br_tgt;
    logic [PC_W-1:0]   br_dist;

    tiny16_decode u_dec (
        .insn (imem_data),
        .dec  (dec)
    );

    tiny16_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (dec.alu_op),
        .x     (rf_q[dec.rx]),
        .y     (rf_q[dec.ry]),
        .res   (alu_res),
        .flags (alu_flags)
    );

    tiny16_retstack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (pc_inc),
        .top_val  (stk_top),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    assign pc_inc  = st_q.pc + 1'b1;
    assign br_dist = PC_W'(dec.off_mag);
    assign br_tgt  = dec.off_neg ? (st_q.pc - br_dist) : (st_q.pc + br_dist);

    assign imem_addr  = st_q.pc;
    assign halted     = st_q.halted;
    assign fault_code = st_q.fault;
    assign out_data   = rf_q[dec.ry];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_rf
        assign rf_d[g] = (rf_we && rf_wa == REG_W'(g)) ? rf_wd : rf_q[g];
    end

    always_comb begin
        case (dec.wb_sel)
            WB_IMM:  rf_wd = {{IMM_PAD{1'b0}}, dec.imm};
            WB_PORT: rf_wd = in_data;
            default: rf_wd = alu_res;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        rf_we     = 1'b0;
        rf_wa     = dec.rd;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        if (!st_q.halted) begin
            case (dec.cls)
                CL_WB: begin
                    rf_we   = 1'b1;
                    st_d.pc = pc_inc;
                end
                CL_CMP: begin
                    st_d.flags = alu_flags;
                    st_d.pc    = pc_inc;
                end
                CL_BCC: begin
                    if (!dec.cond_ok) begin
                        st_d.halted = 1'b1;
                        st_d.fault  = FLT_COND;
                    end else begin
                        st_d.pc = cond_hit(dec.cond, st_q.flags) ? br_tgt : pc_inc;
                    end
                end
                CL_JMP: st_d.pc = dec.abs_tgt;
                CL_CALL: begin
                    if (stk_full) begin
                        st_d.halted = 1'b1;
                        st_d.fault  = FLT_STACK;
                    end else begin
                        stk_push = 1'b1;
                        st_d.pc  = dec.abs_tgt;
                    end
                end
                CL_RET: begin
                    if (stk_empty) begin
                        st_d.halted = 1'b1;
                        st_d.fault  = FLT_STACK;
                    end else begin
                        stk_pop = 1'b1;
                        st_d.pc = stk_top;
                    end
                end
                CL_NOP: st_d.pc = pc_inc;
                CL_IN: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        rf_we   = 1'b1;
                        st_d.pc = pc_inc;
                    end
                end
                CL_OUT: begin
                    out_valid = 1'b1;
                    if (out_ready) begin
                        st_d.pc = pc_inc;
                    end
                end
                default: begin
                    st_d.halted = 1'b1;
                    st_d.fault  = FLT_OPCODE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pc: '0, flags: '0, halted: 1'b0, fault: FLT_NONE};
            for (int i = 0; i < NUM_REGS; i++) begin
                rf_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
            rf_q <= rf_d;
        end
    end

endmodule

// File: rtl/tiny16_core_chk.sv
module tiny16_core_chk
    import tiny16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   imem_addr,
    input logic [INSN_W-1:0] imem_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              halted,
    input logic [1:0]        fault_code
);

    logic [3:0] op;
    assign op = imem_data[15:12];

    p_halt_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(fault_code) && $stable(imem_addr));

    p_fault_matches_halt_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halted == (fault_code != 2'd0));

    p_quiet_when_halted_r13: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !in_ready && !out_valid);

    p_in_ready_only_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (op == OPC_IN) && !halted);

    p_in_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(imem_addr));

    p_out_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(imem_addr));

    p_nop_step_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op == OPC_NOP) |=> imem_addr == PC_W'($past(imem_addr) + 1'b1));

    p_jmp_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op == OPC_JMP) |=> imem_addr == $past(imem_data[PC_W-1:0]));

    p_bad_opcode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op > OPC_MUL) |=> halted && fault_code == 2'd1 && $stable(imem_addr));

    p_bad_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op == OPC_BCC && imem_data[11:8] > LAST_COND) |=> halted && fault_code == 2'd2);

endmodule

bind tiny16_core tiny16_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .halted     (halted),
    .fault_code (fault_code)
);

// File: tb/tiny16_core_tb.sv
module tiny16_core_tb;

    typedef struct packed {
        logic [4:0]  sel;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] e;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{5'h02, 16'h1234, 16'h0FFF, 16'h2233},
        '{5'h02, 16'hFFFF, 16'h0002, 16'h0001},
        '{5'h03, 16'h0005, 16'h0007, 16'hFFFE},
        '{5'h03, 16'h8000, 16'h0001, 16'h7FFF},
        '{5'h0C, 16'h0123, 16'h0100, 16'h2300},
        '{5'h0C, 16'hFFFF, 16'hFFFF, 16'h0001},
        '{5'h0C, 16'h012C, 16'h012C, 16'h5F90},
        '{5'h10, 16'h0007, 16'h0007, 16'h0001},
        '{5'h10, 16'h0007, 16'h0008, 16'h0000},
        '{5'h11, 16'hFFFF, 16'h0001, 16'h0001},
        '{5'h11, 16'h0001, 16'hFFFF, 16'h0000},
        '{5'h12, 16'h7FFF, 16'h8000, 16'h0001},
        '{5'h12, 16'h8000, 16'h7FFF, 16'h0000},
        '{5'h13, 16'h0003, 16'h0003, 16'h0001},
        '{5'h14, 16'h8000, 16'h7FFF, 16'h0000},
        '{5'h15, 16'h0004, 16'h0005, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] imem_addr;
    logic [15:0] imem_data;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        halted;
    logic [1:0]  fault_code;

    logic [15:0] mem [256];
    logic [15:0] in_q [8];
    logic [15:0] out_log [8];
    int          in_cnt = 0;
    int          in_idx = 0;
    int          out_cnt = 0;
    bit          in_pend = 1'b0;
    bit          in_en = 1'b1;
    bit          out_rdy = 1'b1;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    assign imem_data = mem[imem_addr[7:0]];

    tiny16_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .halted     (halted),
        .fault_code (fault_code)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            in_idx    = 0;
            out_cnt   = 0;
            in_pend   = 1'b0;
            in_valid  = 1'b0;
            out_ready = 1'b0;
        end else begin
            if (in_pend) in_idx++;
            in_valid  = in_en && (in_idx < in_cnt);
            in_data   = in_q[in_idx[2:0]];
            in_pend   = in_valid && in_ready;
            out_ready = out_rdy;
            if (out_valid && out_ready && out_cnt < 8) begin
                out_log[out_cnt[2:0]] = out_data;
                out_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'hF000;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        step();
        step();
    endtask

    task automatic release_reset();
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt();
        int n;
        n = 0;
        while (!halted && n < 3000) begin
            step();
            n++;
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #1_500_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        // Vector table: R3 arithmetic and R5 signed conditions
        for (int v = 0; v < NVEC; v++) begin
            clear_mem();
            mem[0] = 16'hA001;
            mem[1] = 16'hA002;
            if (!VECS[v].sel[4]) begin
                mem[2] = {VECS[v].sel[3:0], 12'h312};
                mem[3] = 16'hB003;
            end else begin
                mem[2] = 16'h4012;
                mem[3] = {4'h5, VECS[v].sel[3:0], 8'h03};
                mem[4] = 16'h1300;
                mem[5] = 16'h6007;
                mem[6] = 16'h1301;
                mem[7] = 16'hB003;
            end
            in_q[0] = VECS[v].x;
            in_q[1] = VECS[v].y;
            in_cnt  = 2;
            hold_reset();
            release_reset();
            run_to_halt();
            chk(out_cnt == 1 && out_log[0] == VECS[v].e,
                VECS[v].sel[4] ? "R5 condition vector" : "R3 arithmetic vector",
                {16'(out_cnt), out_log[0]}, {16'd1, VECS[v].e});
        end

        // R1 reset state
        clear_mem();
        mem[0] = 16'h9000;
        mem[1] = 16'hB005;
        in_cnt = 0;
        hold_reset();
        chk(imem_addr == 12'h000 && !halted && fault_code == 2'd0, "R1 in reset",
            {imem_addr, halted, fault_code}, 0);
        release_reset();
        run_to_halt();
        chk(out_cnt == 1 && out_log[0] == 16'h0000, "R1 register cleared", out_log[0], 0);

        // R2 move and zero-extended immediate
        clear_mem();
        mem[0] = 16'h14AB;
        mem[1] = 16'h0064;
        mem[2] = 16'hB006;
        mem[3] = 16'h17FF;
        mem[4] = 16'hB007;
        hold_reset();
        release_reset();
        run_to_halt();
        chk(out_cnt == 2 && out_log[0] == 16'h00AB, "R2 register copy", out_log[0], 16'h00AB);
        chk(out_log[1] == 16'h00FF, "R2 immediate zero-extend", out_log[1], 16'h00FF);

        // R4 compare writes nothing; flags survive a later add
        clear_mem();
        mem[0] = 16'h1309;
        mem[1] = 16'h1105;
        mem[2] = 16'h1205;
        mem[3] = 16'h4012;
        mem[4] = 16'hB003;
        mem[5] = 16'h2412;
        mem[6] = 16'h5002;
        mem[7] = 16'h1300;
        mem[8] = 16'hB003;
        hold_reset();
        release_reset();
        run_to_halt();
        chk(out_cnt == 2 && out_log[0] == 16'h0009, "R4 compare writes no register", out_log[0], 16'h0009);
        chk(out_log[1] == 16'h0009, "R4 flags kept across add", out_log[1], 16'h0009);

        // R6 backward branch loop, then fall through
        clear_mem();
        mem[0] = 16'h1103;
        mem[1] = 16'h1201;
        mem[2] = 16'h1000;
        mem[3] = 16'h3112;
        mem[4] = 16'hB001;
        mem[5] = 16'h4010;
        mem[6] = 16'h5583;
        hold_reset();
        release_reset();
        run_to_halt();
        chk(out_cnt == 3, "R6 loop iterations", out_cnt, 3);
        chk(out_log[0] == 16'd2 && out_log[1] == 16'd1 && out_log[2] == 16'd0, "R6 loop values",
            {out_log[0], out_log[1]}, {16'd2, 16'd1});
        chk(imem_addr == 12'h007 && fault_code == 2'd1, "R6 fall through", imem_addr, 12'h007);

        // R7 absolute jump and address wrap
        clear_mem();
        mem[0]    = 16'h6FFE;
        mem[8'hFE] = 16'h9000;
        mem[8'hFF] = 16'h9000;
        hold_reset();
        release_reset();
        step();
        chk(imem_addr == 12'hFFE, "R7 jump target", imem_addr, 12'hFFE);
        step();
        chk(imem_addr == 12'hFFF, "R7 step to last", imem_addr, 12'hFFF);
        step();
        chk(imem_addr == 12'h000, "R7 wrap to zero", imem_addr, 12'h000);

        // R14 no-op only advances
        clear_mem();
        mem[0] = 16'h9000;
        mem[1] = 16'h9ABC;
        hold_reset();
        release_reset();
        step();
        chk(imem_addr == 12'h001 && !halted, "R14 first step", imem_addr, 1);
        step();
        chk(imem_addr == 12'h002 && !halted, "R14 second step", imem_addr, 2);

        // R8 nested call and return
        clear_mem();
        mem[0]  = 16'h7004;
        mem[1]  = 16'hB001;
        mem[4]  = 16'h1111;
        mem[5]  = 16'h7009;
        mem[6]  = 16'hB001;
        mem[7]  = 16'h1133;
        mem[8]  = 16'h8000;
        mem[9]  = 16'h1122;
        mem[10] = 16'h8000;
        hold_reset();
        release_reset();
        run_to_halt();
        chk(out_cnt == 2 && out_log[0] == 16'h0022, "R8 inner return", out_log[0], 16'h0022);
        chk(out_log[1] == 16'h0033 && imem_addr == 12'h002, "R8 outer return",
            {out_log[1], imem_addr}, {16'h0033, 12'h002});

        // R9 exact depth then overflow; underflow
        clear_mem();
        for (int i = 0; i < 9; i++) mem[i] = 16'h7000 | 16'(i + 1);
        hold_reset();
        release_reset();
        run_to_halt();
        chk(halted && fault_code == 2'd3 && imem_addr == 12'h008, "R9 overflow at ninth call",
            {fault_code, imem_addr}, {2'd3, 12'h008});
        clear_mem();
        mem[0] = 16'h8000;
        hold_reset();
        release_reset();
        run_to_halt();
        chk(fault_code == 2'd3 && imem_addr == 12'h000, "R9 underflow", {fault_code, imem_addr}, {2'd3, 12'h000});

        // R10 illegal opcode and condition; R13 sticky halt
        clear_mem();
        mem[0] = 16'h9000;
        mem[1] = 16'hD000;
        mem[2] = 16'hB000;
        hold_reset();
        release_reset();
        run_to_halt();
        chk(fault_code == 2'd1 && imem_addr == 12'h001, "R10 illegal opcode", {fault_code, imem_addr}, {2'd1, 12'h001});
        in_cnt = 1;
        in_q[0] = 16'h1234;
        repeat (4) step();
        chk(halted && fault_code == 2'd1 && imem_addr == 12'h001 && !out_valid && !in_ready,
            "R13 halt is sticky", {halted, fault_code, imem_addr}, {1'b1, 2'd1, 12'h001});
        in_cnt = 0;
        clear_mem();
        mem[0] = 16'h5601;
        hold_reset();
        release_reset();
        run_to_halt();
        chk(fault_code == 2'd2 && imem_addr == 12'h000, "R10 illegal condition", {fault_code, imem_addr}, {2'd2, 12'h000});

        // R11 input stall
        clear_mem();
        mem[0] = 16'hA002;
        mem[1] = 16'hB002;
        in_en  = 1'b0;
        in_q[0] = 16'hBEEF;
        in_cnt = 1;
        hold_reset();
        release_reset();
        repeat (5) step();
        chk(imem_addr == 12'h000 && in_ready, "R11 stall without valid", {in_ready, imem_addr}, {1'b1, 12'h000});
        in_en = 1'b1;
        run_to_halt();
        chk(out_cnt == 1 && out_log[0] == 16'hBEEF, "R11 input written", out_log[0], 16'hBEEF);

        // R12 output stall
        clear_mem();
        mem[0]  = 16'h115A;
        mem[1]  = 16'hB001;
        out_rdy = 1'b0;
        in_cnt  = 0;
        hold_reset();
        release_reset();
        repeat (5) step();
        chk(out_valid && out_data == 16'h005A && imem_addr == 12'h001, "R12 stall without ready",
            {out_valid, out_data, imem_addr}, {1'b1, 16'h005A, 12'h001});
        out_rdy = 1'b1;
        run_to_halt();
        chk(out_cnt == 1 && out_log[0] == 16'h005A && imem_addr == 12'h002, "R12 output accepted",
            {out_log[0], imem_addr}, {16'h005A, 12'h002});

        summary();
        $finish;
    end

endmodule